// File: doc/BRIEF.md
# Indirect Coefficient RAM Access Port

This block lets a host reach three internal word RAMs through two registers on its direct register bus: a gain profile table, an in-phase coefficient table and a quadrature coefficient table. The host places a word in the data register. It then writes a 16-bit indirect address into the address register. That write starts an access. After a fixed synchronization delay of four device clocks, the block either stores the latched data word into the addressed RAM word or copies the addressed word back into the data register. Bit 15 of the indirect address chooses between these two cases.

Bits 9:8 of the indirect address select a 256-word page, and each page belongs to one of the RAMs. Bits 7:0 select the word within the page. A busy flag covers the delay. The block enforces the minimum spacing between writes to the same register. A write that comes too early is dropped and recorded in a sticky error flag. Writes that alternate between the two registers may follow each other on consecutive cycles.

Top module: `coef_ram_port`

## Requirements
- R1: A host write to address 0x14 loads host_wdata into the data register, and data_q shows it after that edge. A write to any address other than 0x14 or 0x15 changes neither data_q nor addr_q.
- R2: An accepted host write to address 0x15 loads host_wdata into the address register (addr_q). It also raises busy for exactly four cycles.
- R3: When bit 15 of the accepted address is 0, the data value held at acceptance is stored on the fourth edge after acceptance. It goes into word [7:0] of the page selected by bits [9:8].
- R4: When bit 15 is 1, the addressed word is copied into data_q on the fourth edge after acceptance.
- R5: Page 0 selects the gain RAM, page 1 the in-phase RAM and page 2 the quadrature RAM, and the three are independent. An access to page 3 stores nothing and leaves data_q unchanged.
- R6: A write to 0x15 while busy is high, before the completion edge, is ignored and sets the error flag. A write to 0x15 on the completion edge itself is accepted.
- R7: A write to 0x14 fewer than four edges after the previous accepted write to 0x14 is ignored and sets the error flag.
- R8: The data register may be rewritten while an access is pending. A write access still stores the value captured at acceptance.
- R9: If a host write to 0x14 and a read return fall on the same edge, data_q takes the host value.
- R10: Reset clears data_q, addr_q, busy and the error flag.
- R11: Once set, the error flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 7 | Host direct register address |
| host_wdata | input | 16 | Host write data |
| data_q | output | 16 | Data register contents |
| addr_q | output | 16 | Address register contents |
| busy | output | 1 | Access in its synchronization delay |
| spacing_err | output | 1 | Sticky spacing violation flag |

## Verification
On every cycle, assertions check that:
- a started access raises busy;
- rejected writes leave the address register and the data register untouched;
- any rejection sets the error flag, and the flag never falls;
- at most one RAM is written in a cycle, and page 3 is never written.

The bench's scenarios carry what needs a history of several accesses: the four-edge timing of each commit, the mapping of pages to RAMs shown by read-back, use of the data value captured at acceptance, the priority of a host write over a read return, and acceptance exactly on the completion edge.

// File: rtl/coef_ram_pkg.sv
package coef_ram_pkg;
  localparam int IND_W    = 16;
  localparam int RW_BIT   = 15;
  localparam int PAGE_LSB = 8;
  localparam int PAGE_W   = 2;

  typedef enum logic [PAGE_W-1:0] {
    PG_GAIN  = 2'd0,
    PG_ICOEF = 2'd1,
    PG_QCOEF = 2'd2,
    PG_NONE  = 2'd3
  } page_e;

  function automatic page_e page_of(input logic [IND_W-1:0] a);
    return page_e'(a[PAGE_LSB +: PAGE_W]);
  endfunction

  function automatic logic [PAGE_LSB-1:0] word_of(input logic [IND_W-1:0] a);
    return a[PAGE_LSB-1:0];
  endfunction

  function automatic logic is_read(input logic [IND_W-1:0] a);
    return a[RW_BIT];
  endfunction
endpackage

// File: rtl/coef_host_decode.sv
module coef_host_decode #(
  parameter int HADDR_W   = 7,
  parameter int DATA_ADDR = 'h14,
  parameter int RADR_ADDR = 'h15,
  parameter int SYNC_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [HADDR_W-1:0] haddr,
  output logic               data_load,
  output logic               data_viol,
  output logic               addr_hit
);
  localparam int GW = $clog2(SYNC_CLKS + 1);

  logic [GW-1:0] guard_q;
  logic          data_hit;

  assign data_hit  = we && (haddr == HADDR_W'(DATA_ADDR));
  assign addr_hit  = we && (haddr == HADDR_W'(RADR_ADDR));
  assign data_load = data_hit && (guard_q == '0);
  assign data_viol = data_hit && (guard_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            guard_q <= '0;
    else if (data_load)    guard_q <= GW'(SYNC_CLKS - 1);
    else if (guard_q != 0) guard_q <= guard_q - 1'b1;
  end

  AST_DATA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_load && data_viol)); // R7
endmodule

// File: rtl/coef_sync_timer.sv
module coef_sync_timer #(
  parameter int SYNC_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hit,
  output logic acc_start,
  output logic acc_commit,
  output logic addr_viol,
  output logic busy
);
  localparam int CW = $clog2(SYNC_CLKS + 1);

  logic [CW-1:0] cnt_q;

  assign acc_commit = busy && (cnt_q == '0);
  assign acc_start  = addr_hit && (!busy || acc_commit);
  assign addr_viol  = addr_hit && !acc_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (acc_start) begin
      busy  <= 1'b1;
      cnt_q <= CW'(SYNC_CLKS - 1);
    end else if (acc_commit) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> busy); // R2
  AST_NO_EARLY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !acc_commit); // R3
endmodule

// File: rtl/coef_ram_bank.sv
module coef_ram_bank #(
  parameter int DATA_W  = 16,
  parameter int WORD_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         page,
  input  logic [WORD_AW-1:0] word,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata
);
  localparam int NBANK = 3;
  localparam int DEPTH = 1 << WORD_AW;

  logic [NBANK-1:0]  bank_we;
  logic [DATA_W-1:0] bank_rd [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    assign bank_we[g] = wr_en && (page == 2'(g));
    assign bank_rd[g] = mem[word];
    always_ff @(posedge clk) begin
      if (bank_we[g]) mem[word] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBANK; i++)
      if (page == 2'(i)) rdata = bank_rd[i];
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we)); // R5
  AST_NO_PAGE3_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (page == 2'd3) |-> (bank_we == '0)); // R5
endmodule

// File: rtl/coef_ram_port.sv
module coef_ram_port
  import coef_ram_pkg::*;
#(
  parameter int HADDR_W   = 7,
  parameter int DATA_ADDR = 'h14,
  parameter int RADR_ADDR = 'h15,
  parameter int SYNC_CLKS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [IND_W-1:0]   host_wdata,
  output logic [IND_W-1:0]   data_q,
  output logic [IND_W-1:0]   addr_q,
  output logic               busy,
  output logic               spacing_err
);
  logic             data_load, data_viol, addr_hit;
  logic             acc_start, acc_commit, addr_viol;
  logic             rd_return, ram_we;
  logic [IND_W-1:0] snap_q, ram_rdata;
  page_e            cur_page;

  coef_host_decode #(
    .HADDR_W(HADDR_W), .DATA_ADDR(DATA_ADDR),
    .RADR_ADDR(RADR_ADDR), .SYNC_CLKS(SYNC_CLKS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .we(host_we), .haddr(host_addr),
    .data_load(data_load), .data_viol(data_viol), .addr_hit(addr_hit)
  );

  coef_sync_timer #(.SYNC_CLKS(SYNC_CLKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit),
    .acc_start(acc_start), .acc_commit(acc_commit),
    .addr_viol(addr_viol), .busy(busy)
  );

  assign cur_page  = page_of(addr_q);
  assign rd_return = acc_commit && is_read(addr_q) && (cur_page != PG_NONE);
  assign ram_we    = acc_commit && !is_read(addr_q);

  coef_ram_bank #(.DATA_W(IND_W), .WORD_AW(PAGE_LSB)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(ram_we), .page(cur_page),
    .word(word_of(addr_q)), .wdata(snap_q), .rdata(ram_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q      <= '0;
      addr_q      <= '0;
      snap_q      <= '0;
      spacing_err <= 1'b0;
    end else begin
      if (data_load)      data_q <= host_wdata;
      else if (rd_return) data_q <= ram_rdata;
      if (acc_start) begin
        addr_q <= host_wdata;
        snap_q <= data_q;
      end
      if (addr_viol || data_viol) spacing_err <= 1'b1;
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    addr_viol |=> $stable(addr_q)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_viol && !rd_return) |=> $stable(data_q)); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_viol || data_viol) |=> spacing_err); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    spacing_err |=> spacing_err); // R11
endmodule

// File: tb/coef_ram_port_tb.sv
module coef_ram_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] data_q, addr_q;
  logic        busy, spacing_err;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  coef_ram_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .data_q(data_q), .addr_q(addr_q),
    .busy(busy), .spacing_err(spacing_err)
  );

  // Behavioural reference: remaining delay count, edges since last data load.
  int          m_left = 0;
  int          m_since = 100;
  logic [15:0] m_data = '0, m_addr = '0, m_snap = '0, nd;
  bit          m_err = 0;
  logic [15:0] m_mem [768];
  bit          fin;
  int          pg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_since = 100; m_data = '0; m_addr = '0; m_snap = '0; m_err = 0;
    end else begin
      fin = (m_left == 1);
      if (m_left > 0) m_left--;
      pg = int'(m_addr[9:8]);
      nd = m_data;
      if (fin && pg != 3) begin
        if (m_addr[15]) nd = m_mem[pg*256 + int'(m_addr[7:0])];
        else m_mem[pg*256 + int'(m_addr[7:0])] = m_snap;
      end
      m_since++;
      if (host_we && host_addr == 7'h14) begin
        if (m_since >= 4) begin nd = host_wdata; m_since = 0; end
        else m_err = 1;
      end
      if (host_we && host_addr == 7'h15) begin
        if (m_left == 0) begin m_addr = host_wdata; m_snap = m_data; m_left = 4; end
        else m_err = 1;
      end
      m_data = nd;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 per-cycle data", data_q, m_data);
      chk("R2 per-cycle addr", addr_q, m_addr);
      chk("R2 per-cycle busy", 16'(busy), 16'(m_left > 0));
      chk("R11 per-cycle err", 16'(spacing_err), 16'(m_err));
    end
  end

  task automatic hw(input logic [6:0] a, input logic [15:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_access(input logic [15:0] d, input logic [15:0] a);
    hw(7'h14, d); idle(3); hw(7'h15, a); idle(8);
  endtask

  task automatic rd_access(input logic [15:0] a);
    hw(7'h15, a); idle(8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset data", data_q, 16'h0);
    chk("R10 reset busy", 16'(busy), 16'h0);
    rst_n = 1'b1;
    idle(1);
    chk("R10 reset addr", addr_q, 16'h0);
    chk("R10 reset err", 16'(spacing_err), 16'h0);

    hw(7'h16, 16'hdead); idle(4);
    chk("R1 other address ignored", data_q, 16'h0);
    hw(7'h14, 16'h0abc); idle(4);
    chk("R1 data load", data_q, 16'h0abc);

    hw(7'h14, 16'h1111); idle(3); hw(7'h15, 16'h0005);
    chk("R2 busy right after start", 16'(busy), 16'h1);
    idle(3);
    chk("R2 busy on fourth cycle", 16'(busy), 16'h1);
    idle(1);
    chk("R2 busy dropped", 16'(busy), 16'h0);
    idle(4);
    wr_access(16'h2222, 16'h0105);
    wr_access(16'h3333, 16'h0205);
    wr_access(16'h4444, 16'h0305);
    chk("R2 addr register", addr_q, 16'h0305);

    rd_access(16'h8005);
    chk("R3 R4 gain read back", data_q, 16'h1111);
    rd_access(16'h8105);
    chk("R5 in-phase page", data_q, 16'h2222);
    rd_access(16'h8205);
    chk("R5 quadrature page", data_q, 16'h3333);
    rd_access(16'h8305);
    chk("R5 page 3 read no effect", data_q, 16'h3333);

    hw(7'h14, 16'h5555); idle(3); hw(7'h15, 16'h0010); idle(3);
    hw(7'h15, 16'h8010); idle(6);
    chk("R6 accept on completion edge", data_q, 16'h5555);
    chk("R6 no error on completion edge", 16'(spacing_err), 16'h0);

    hw(7'h14, 16'h6666); idle(3); hw(7'h15, 16'h0111);
    hw(7'h14, 16'h7777); idle(8);
    chk("R8 data rewritten while pending", data_q, 16'h7777);
    rd_access(16'h8111);
    chk("R8 captured value stored", data_q, 16'h6666);

    hw(7'h15, 16'h8005); idle(3); hw(7'h14, 16'h9999); idle(4);
    chk("R9 host write beats read return", data_q, 16'h9999);
    chk("R4 no error so far", 16'(spacing_err), 16'h0);

    hw(7'h14, 16'haaaa); hw(7'h14, 16'hbbbb); idle(1);
    chk("R7 early data write ignored", data_q, 16'haaaa);
    chk("R7 error set", 16'(spacing_err), 16'h1);
    idle(5);
    hw(7'h15, 16'h0301); hw(7'h15, 16'h0302); idle(1);
    chk("R6 early address write ignored", addr_q, 16'h0301);
    idle(10);
    chk("R11 error sticky", 16'(spacing_err), 16'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule